// File: doc/BRIEF.md
# Egress Burst Scheduler with Status/Credit Flow Control

This block decides which logical channel of a packet egress port transmits next and how many 16-byte units that burst may carry. Each channel reports a two-bit FIFO condition from the far end, a count of queued 16-byte units, a flag saying the queued data closes a packet, and an enable. Two per-channel limits are held outside the block. One applies when the channel is starving and the other when it is hungry. The scheduler issues one grant at a time and holds it until the data mover signals that the burst has gone.

A single mode input sets how the flow-control channel is read. In level mode the two-bit code alone decides eligibility, so a channel keeps winning grants for as long as its code stays unchanged. In credit mode each one-cycle credit pulse adds one unit to a saturating per-channel counter. Every issued grant spends one unit, and a channel whose counter is empty is not served. Starving channels and hungry channels are searched in two separate round-robin passes. Any starving candidate beats every hungry one.

Top module: `egress_burst_sched`

## Requirements
- R1: After reset, `grantValid` is 0 and every credit counter is 0, so in credit mode no grant is issued until credits arrive.
- R2: Status codes per channel in `chStatus[2i+1:2i]` are 2'b00 starving, 2'b01 hungry, 2'b10 satisfied, 2'b11 reserved; satisfied and reserved channels are never granted.
- R3: When at least one starving candidate exists, the grant goes to a starving channel and `grantHigh` is 1, regardless of hungry candidates.
- R4: A starving channel's limit is `maxBurstS[4i+3:4i]` and a hungry channel's limit is `maxBurstH[4i+3:4i]`; when `chOccupancy[8i+7:8i]` is at least the limit, `grantBurst` equals the limit.
- R5: When occupancy is nonzero but below the limit, the channel is granted a burst equal to its occupancy only if `chLastFrag[i]` is 1; otherwise it waits, and `grantBurst` is never 0.
- R6: A channel with `chEnable[i]` low, zero occupancy, or a zero limit is skipped.
- R7: Within each class the search starts at the channel after the last one served in that class; after reset both class pointers sit at channel NUM_CH-1, so the first search begins at channel 0.
- R8: In level mode (`creditMode`=0) an eligible channel is granted again and again for as long as its status code holds.
- R9: In credit mode (`creditMode`=1) a grant needs a nonzero counter; each `creditPulse[i]` adds one, saturating at 15, and each grant to channel i subtracts one.
- R10: A grant keeps `grantValid`, `grantCh` and `grantBurst` steady until `doneIn` is sampled high; the next edge clears `grantValid`, and a new grant can load on the edge after that.
- R11: A credit pulse arriving in the same cycle as a grant to that channel leaves its counter unchanged, including at saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| creditMode | input | 1 | 0 = level status, 1 = credit counting |
| chEnable | input | NUM_CH | Per-channel enable |
| chStatus | input | 2*NUM_CH | Per-channel two-bit FIFO condition |
| creditPulse | input | NUM_CH | One-cycle credit arrivals |
| chOccupancy | input | OCC_W*NUM_CH | Queued 16-byte units per channel |
| chLastFrag | input | NUM_CH | Queued data ends a packet |
| maxBurstS | input | BURST_W*NUM_CH | Starving burst limit per channel |
| maxBurstH | input | BURST_W*NUM_CH | Hungry burst limit per channel |
| doneIn | input | 1 | Data mover has sent the granted burst |
| grantValid | output | 1 | A grant is outstanding |
| grantCh | output | CH_W | Granted channel |
| grantBurst | output | BURST_W | Granted size in 16-byte units |
| grantHigh | output | 1 | Grant came from the starving pass |

## Verification
Credit arrival and credit spending can land on the same counter in the same cycle. The bench provokes this by raising a channel's credit pulse on exactly the edge where that channel's grant loads. It judges the result by counting how many further grants the channel receives before it goes quiet. A second overlap is a grant release followed by the next search, which the bench times edge by edge to confirm there is one idle cycle and then a fresh grant.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    ST_STARVING  = 2'b00,
    ST_HUNGRY    = 2'b01,
    ST_SATISFIED = 2'b10,
    ST_RESERVED  = 2'b11
  } chStatus_e;

  typedef struct packed {
    logic loadGrant;
    logic clearGrant;
  } ctrlStrobe_t;
endpackage

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyCand,
  input  logic        doneIn,
  output ctrlStrobe_t strobe
);
  typedef enum logic {S_IDLE, S_BUSY} state_e;
  state_e state, stateNext;

  always_comb begin
    strobe.loadGrant  = (state == S_IDLE) && anyCand;
    strobe.clearGrant = (state == S_BUSY) && doneIn;
    stateNext = state;
    if (strobe.loadGrant)  stateNext = S_BUSY;
    if (strobe.clearGrant) stateNext = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  p_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BUSY && doneIn) |=> (state == S_IDLE));
  p_no_load_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BUSY) |-> !strobe.loadGrant);
endmodule

// File: rtl/sched_datapath.sv
module sched_datapath
  import sched_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int BURST_W    = 4,
  parameter int OCC_W      = 8,
  parameter int CREDIT_MAX = 15,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W     = $clog2(CREDIT_MAX + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      creditMode,
  input  logic [NUM_CH-1:0]         chEnable,
  input  logic [2*NUM_CH-1:0]       chStatus,
  input  logic [NUM_CH-1:0]         creditPulse,
  input  logic [OCC_W*NUM_CH-1:0]   chOccupancy,
  input  logic [NUM_CH-1:0]         chLastFrag,
  input  logic [BURST_W*NUM_CH-1:0] maxBurstS,
  input  logic [BURST_W*NUM_CH-1:0] maxBurstH,
  input  ctrlStrobe_t               strobe,
  output logic                      anyCand,
  output logic                      grantValid,
  output logic [CH_W-1:0]           grantCh,
  output logic [BURST_W-1:0]        grantBurst,
  output logic                      grantHigh
);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CREDIT_MAX);
  localparam logic [CH_W-1:0]  PTR_INIT = CH_W'(NUM_CH - 1);

  logic [NUM_CH-1:0]  hiMask, loMask;
  logic [BURST_W-1:0] burstAmt [NUM_CH];
  logic [CNT_W-1:0]   creditCnt [NUM_CH];
  logic [CH_W-1:0]    hiPtr, loPtr, hiSel, loSel, pickCh;
  logic               anyHi;

  function automatic logic [CH_W-1:0] rrPick(input logic [NUM_CH-1:0] mask,
                                             input logic [CH_W-1:0] ptr);
    logic [CH_W-1:0] sel;
    sel = ptr;
    for (int off = NUM_CH; off >= 1; off--) begin
      int idx;
      idx = (int'(ptr) + off) % NUM_CH;
      if (mask[idx]) sel = CH_W'(idx);
    end
    return sel;
  endfunction

  assign anyHi   = |hiMask;
  assign anyCand = anyHi | (|loMask);
  assign hiSel   = rrPick(hiMask, hiPtr);
  assign loSel   = rrPick(loMask, loPtr);
  assign pickCh  = anyHi ? hiSel : loSel;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    chStatus_e          st;
    logic [BURST_W-1:0] limit;
    logic [OCC_W-1:0]   occ;
    logic               fullBurst, shortOk, creditOk, elig;
    logic               inc, dec;
    logic [CNT_W-1:0]   cntNext;

    assign st        = chStatus_e'(chStatus[2*i +: 2]);
    assign limit     = (st == ST_STARVING) ? maxBurstS[BURST_W*i +: BURST_W]
                                           : maxBurstH[BURST_W*i +: BURST_W];
    assign occ       = chOccupancy[OCC_W*i +: OCC_W];
    assign fullBurst = occ >= OCC_W'(limit);
    assign shortOk   = chLastFrag[i] && (occ != '0);
    assign creditOk  = !creditMode || (creditCnt[i] != '0);
    assign elig      = chEnable[i] && (limit != '0) && (occ != '0)
                       && (fullBurst || shortOk) && creditOk;
    assign hiMask[i] = elig && (st == ST_STARVING);
    assign loMask[i] = elig && (st == ST_HUNGRY);
    assign burstAmt[i] = fullBurst ? limit : occ[BURST_W-1:0];

    assign dec     = strobe.loadGrant && creditMode && (pickCh == CH_W'(i));
    assign inc     = creditPulse[i] && ((creditCnt[i] != CNT_TOP) || dec);
    assign cntNext = creditCnt[i] + CNT_W'(inc) - CNT_W'(dec);

    always_ff @(posedge clk) begin
      if (!rstN) creditCnt[i] <= '0;
      else       creditCnt[i] <= cntNext;
    end

    p_credit_cap_r9: assert property (@(posedge clk) disable iff (!rstN)
      (creditCnt[i] == CNT_TOP && creditPulse[i] && !dec) |=> (creditCnt[i] == CNT_TOP));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      grantCh    <= '0;
      grantBurst <= '0;
      grantHigh  <= 1'b0;
      hiPtr      <= PTR_INIT;
      loPtr      <= PTR_INIT;
    end else if (strobe.loadGrant) begin
      grantValid <= 1'b1;
      grantCh    <= pickCh;
      grantBurst <= burstAmt[pickCh];
      grantHigh  <= anyHi;
      if (anyHi) hiPtr <= pickCh;
      else       loPtr <= pickCh;
    end else if (strobe.clearGrant) begin
      grantValid <= 1'b0;
    end
  end

  p_pick_eligible_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadGrant |-> (hiMask[pickCh] || loMask[pickCh]));
  p_credit_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadGrant && creditMode) |-> (creditCnt[pickCh] != '0));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !strobe.clearGrant) |=>
      (grantValid && $stable(grantCh) && $stable(grantBurst)));
  p_burst_nonzero_r5: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (grantBurst != '0));
  p_high_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadGrant && (|hiMask)) |=> grantHigh);
endmodule

// File: rtl/egress_burst_sched.sv
module egress_burst_sched
  import sched_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int BURST_W    = 4,
  parameter int OCC_W      = 8,
  parameter int CREDIT_MAX = 15,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      creditMode,
  input  logic [NUM_CH-1:0]         chEnable,
  input  logic [2*NUM_CH-1:0]       chStatus,
  input  logic [NUM_CH-1:0]         creditPulse,
  input  logic [OCC_W*NUM_CH-1:0]   chOccupancy,
  input  logic [NUM_CH-1:0]         chLastFrag,
  input  logic [BURST_W*NUM_CH-1:0] maxBurstS,
  input  logic [BURST_W*NUM_CH-1:0] maxBurstH,
  input  logic                      doneIn,
  output logic                      grantValid,
  output logic [CH_W-1:0]           grantCh,
  output logic [BURST_W-1:0]        grantBurst,
  output logic                      grantHigh
);
  ctrlStrobe_t strobe;
  logic        anyCand;

  sched_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .anyCand (anyCand),
    .doneIn  (doneIn),
    .strobe  (strobe)
  );

  sched_datapath #(
    .NUM_CH     (NUM_CH),
    .BURST_W    (BURST_W),
    .OCC_W      (OCC_W),
    .CREDIT_MAX (CREDIT_MAX)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .creditMode  (creditMode),
    .chEnable    (chEnable),
    .chStatus    (chStatus),
    .creditPulse (creditPulse),
    .chOccupancy (chOccupancy),
    .chLastFrag  (chLastFrag),
    .maxBurstS   (maxBurstS),
    .maxBurstH   (maxBurstH),
    .strobe      (strobe),
    .anyCand     (anyCand),
    .grantValid  (grantValid),
    .grantCh     (grantCh),
    .grantBurst  (grantBurst),
    .grantHigh   (grantHigh)
  );
endmodule

// File: tb/egress_burst_sched_tb.sv
module egress_burst_sched_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        creditMode = 1'b0;
  logic [3:0]  chEnable = '0;
  logic [7:0]  chStatus = '0;
  logic [3:0]  creditPulse = '0;
  logic [31:0] chOccupancy = '0;
  logic [3:0]  chLastFrag = '0;
  logic [15:0] maxBurstS = 16'h2444;
  logic [15:0] maxBurstH = 16'h3222;
  logic        doneIn = 1'b0;
  logic        grantValid;
  logic [1:0]  grantCh;
  logic [3:0]  grantBurst;
  logic        grantHigh;

  int nRun = 0;
  int nFail = 0;

  egress_burst_sched u_dut (
    .clk(clk), .rstN(rstN), .creditMode(creditMode), .chEnable(chEnable),
    .chStatus(chStatus), .creditPulse(creditPulse), .chOccupancy(chOccupancy),
    .chLastFrag(chLastFrag), .maxBurstS(maxBurstS), .maxBurstH(maxBurstH),
    .doneIn(doneIn), .grantValid(grantValid), .grantCh(grantCh),
    .grantBurst(grantBurst), .grantHigh(grantHigh)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic [3:0]  en;
    logic [7:0]  st;
    logic [31:0] occ;
    logic [3:0]  last;
    logic        expV;
    logic [1:0]  expCh;
    logic [3:0]  expB;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{4'hF, 8'h00, 32'h0A0A0A0A, 4'h0, 1'b1, 2'd0, 4'd4},  // R2 R4 R7 starving ch0
    '{4'hF, 8'h00, 32'h0A0A0A0A, 4'h0, 1'b1, 2'd1, 4'd4},  // R7 next
    '{4'hF, 8'h65, 32'h0A0A0A0A, 4'h0, 1'b1, 2'd0, 4'd2},  // R4 hungry limit
    '{4'hF, 8'h65, 32'h0A0A0A0A, 4'h0, 1'b1, 2'd1, 4'd2},  // R7
    '{4'hF, 8'h65, 32'h0A0A0A0A, 4'h0, 1'b1, 2'd3, 4'd3},  // R2 satisfied skipped
    '{4'hF, 8'h45, 32'h0A0A0A0A, 4'h0, 1'b1, 2'd2, 4'd4},  // R3 starving wins
    '{4'hE, 8'h65, 32'h0A0A0A0A, 4'h0, 1'b1, 2'd1, 4'd2},  // R6 disabled skipped
    '{4'hF, 8'h00, 32'h01000000, 4'h0, 1'b0, 2'd0, 4'd0},  // R5 short, not last
    '{4'hF, 8'h00, 32'h01000000, 4'h8, 1'b1, 2'd3, 4'd1},  // R5 short last
    '{4'hF, 8'hFF, 32'h0A0A0A0A, 4'h0, 1'b0, 2'd0, 4'd0},  // R2 reserved
    '{4'h2, 8'h00, 32'h0A0A0A0A, 4'h0, 1'b1, 2'd1, 4'd4},  // R8
    '{4'h2, 8'h00, 32'h0A0A0A0A, 4'h0, 1'b1, 2'd1, 4'd4}   // R8 again
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic release_grant();
    doneIn = 1'b1;
    @(posedge clk); #5;
    doneIn = 1'b0;
  endtask

  // one edge, then report whether a grant loaded; release it if so
  task automatic step_grant(output logic v, output logic [1:0] ch, output logic [3:0] b);
    @(posedge clk); #5;
    v = grantValid; ch = grantCh; b = grantBurst;
    if (v) release_grant();
  endtask

  initial begin
    #(20 * 200000);
    nFail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic v;
    logic [1:0] ch;
    logic [3:0] b;
    int cnt;

    repeat (3) @(posedge clk);
    #5;
    check("R1", "grantValid in reset", int'(grantValid), 0);
    rstN = 1'b1;
    @(posedge clk); #5;
    check("R1", "grantValid after reset", int'(grantValid), 0);

    for (int k = 0; k < NVEC; k++) begin
      chEnable = VEC[k].en; chStatus = VEC[k].st;
      chOccupancy = VEC[k].occ; chLastFrag = VEC[k].last;
      step_grant(v, ch, b);
      check("R2-vec", $sformatf("vec %0d valid", k), int'(v), int'(VEC[k].expV));
      if (VEC[k].expV) begin
        check("R7-vec", $sformatf("vec %0d ch", k), int'(ch), int'(VEC[k].expCh));
        check("R4-vec", $sformatf("vec %0d burst", k), int'(b), int'(VEC[k].expB));
      end
    end

    // R10: hold until done, one idle cycle, then regrant
    chEnable = 4'h1; chStatus = 8'h00; chOccupancy = 32'h0A0A0A0A; chLastFrag = '0;
    @(posedge clk); #5;
    check("R10", "grant up", int'(grantValid), 1);
    check("R10", "grant ch", int'(grantCh), 0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #5;
      check("R10", "held valid", int'(grantValid), 1);
      check("R10", "held ch", int'(grantCh), 0);
    end
    release_grant();
    check("R10", "cleared after done", int'(grantValid), 0);
    @(posedge clk); #5;
    check("R10", "regrant after idle", int'(grantValid), 1);
    release_grant();

    // R1 R9: credit mode with empty counters gives nothing
    chEnable = 4'h0;
    @(posedge clk); #5;
    creditMode = 1'b1;
    chEnable = 4'hF;
    step_grant(v, ch, b);
    check("R1", "no grant without credit", int'(v), 0);

    // R9: two credits to ch0 -> exactly two grants
    chEnable = 4'h0;
    creditPulse = 4'h1;
    repeat (2) @(posedge clk);
    #5 creditPulse = '0;
    chEnable = 4'h1;
    cnt = 0;
    for (int k = 0; k < 5; k++) begin
      step_grant(v, ch, b);
      if (v) cnt++;
    end
    check("R9", "grants from two credits", cnt, 2);

    // R9: saturation at 15 on ch1
    chEnable = 4'h0;
    creditPulse = 4'h2;
    repeat (20) @(posedge clk);
    #5 creditPulse = '0;
    chEnable = 4'h2;
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      step_grant(v, ch, b);
      if (v) cnt++;
    end
    check("R9", "grants after saturation", cnt, 15);

    // R11: pulse on the grant edge keeps the counter
    chEnable = 4'h0;
    creditPulse = 4'h4;
    @(posedge clk); #5;
    creditPulse = 4'h4;
    chEnable = 4'h4;
    @(posedge clk); #5;
    creditPulse = '0;
    check("R11", "grant on pulse edge", int'(grantValid), 1);
    release_grant();
    cnt = 0;
    for (int k = 0; k < 4; k++) begin
      step_grant(v, ch, b);
      if (v) cnt++;
    end
    check("R11", "grants left after overlap", cnt, 1);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule